// File: doc/BRIEF.md
# Sparse 8x8 Inverse DCT with Reconstruction

This block reconstructs an 8x8 tile of 8-bit pixels from a prediction and a set of transform coefficients, for the case where every nonzero coefficient sits in the low-frequency 4x4 corner. The caller decides that a block is sparse and hands over only those sixteen coefficients. It also hands over the 64 prediction pixels. One cycle or two later (set by a parameter), the block returns the 64 reconstructed pixels.

The row pass runs on four rows only. It drops every product whose input is known to be zero. Each single-term product becomes a saturating, rounding, doubling high-half multiply by a doubled 14-bit cosine constant. This gives exactly the same value as a full multiply followed by a 14-bit rounding shift. The 4-by-8 intermediate is then turned into eight columns. The column pass uses the same pruned butterfly. Each residual is rounded down by 5 bits, added to the prediction and clamped to the 8-bit pixel range. All butterfly sums wrap to 16 bits, so the result is bit-identical to a full 8x8 transform of the same block.

Top module: `sparse_idct8_recon`

## Requirements
- R1: Only the sixteen corner coefficients are inputs. Coefficient (row r, column c), with r and c in 0..3, is a signed 16-bit value at `coef_in[(r*4+c)*16 +: 16]`. The output equals a full two-dimensional 8x8 inverse DCT (rows first, then columns) of the block with all other coefficients zero, bit for bit.
- R2: Each single-term product is computed as (2·a·(2k) + 32768) >> 16, saturated to 16 bits. Here k is the 14-bit cosine constant (4: 16069, 8: 15137, 12: 13623, 16: 11585, 20: 9102, 24: 6270, 28: 3196). The result equals a·k rounded by 14 bits.
- R3: The odd-half rotation (difference and sum of the two middle odd terms times the 16 constant) uses a full 32-bit sum of products before one rounding 14-bit shift, truncated to 16 bits.
- R4: Each column output v becomes the residual (v + 16) >> 5 (arithmetic shift). This is added to the prediction, and the sum is clamped to 0..255. Pixel (row m, column k) is at `pred_in[(m*8+k)*8 +: 8]` and `pix_out[(m*8+k)*8 +: 8]`.
- R5: A block whose only nonzero coefficient is (0,0) gives the same residual at all 64 pixels.
- R6: `out_valid` is high for exactly one cycle, 1 + REG_MID cycles after `in_valid`. `pix_out` changes only on that update and holds its value while no new block arrives, whatever the data inputs do.
- R7: While reset is low, `out_valid` and `pix_out` are cleared to zero.
- R8: An all-zero coefficient set returns the prediction unchanged.
- R9: A residual that pushes a pixel above 255 gives 255, and one that pushes it below 0 gives 0.
- R10: Butterfly sums and differences wrap to 16 bits, the same as in the full transform, for coefficients anywhere in the signed 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficients and prediction are presented this cycle |
| coef_in | input | 256 | Sixteen signed corner coefficients, row-major |
| pred_in | input | 512 | 64 prediction pixels, row-major |
| out_valid | output | 1 | Reconstructed block is on `pix_out` this cycle |
| pix_out | output | 512 | 64 reconstructed pixels, row-major |

## Verification
The bench builds two copies of the block with the default 16-bit coefficients and 8-bit pixels. One copy uses REG_MID=1 (registered between passes) and the other uses REG_MID=0 (single cycle). Both latency variants and their hold behaviour are checked against the same expected tiles. The expected tiles come from a full eight-input transform model, so the pruning is checked for bit-exact agreement on random sparse blocks. Full-range coefficients reach the 16-bit wrap paths, and large DC values with extreme predictions reach both clamp limits.

// File: rtl/spidct_pkg.sv
package spidct_pkg;
   typedef logic signed [15:0] s16_t;

   // 14-bit cosine constants
   localparam s16_t K4  = 16'sd16069;
   localparam s16_t K8  = 16'sd15137;
   localparam s16_t K12 = 16'sd13623;
   localparam s16_t K16 = 16'sd11585;
   localparam s16_t K20 = 16'sd9102;
   localparam s16_t K24 = 16'sd6270;
   localparam s16_t K28 = 16'sd3196;

   // saturating rounding doubling high-half multiply
   function automatic s16_t qdmulh(input s16_t a, input s16_t k2);
      logic signed [35:0] prod;
      logic signed [35:0] hi;
      prod = (36'(a) * 36'(k2)) <<< 1;
      prod = prod + 36'sd32768;
      hi   = prod >>> 16;
      if (hi > 36'sd32767)       return s16_t'(16'h7fff);
      else if (hi < -36'sd32768) return s16_t'(16'h8000);
      else                       return s16_t'(hi[15:0]);
   endfunction

   // p*K16 +/- q*K16, rounded by 14, narrowed to 16 bits
   function automatic s16_t rot14(input s16_t p, input s16_t q, input logic neg);
      logic signed [33:0] acc;
      logic signed [33:0] term;
      acc  = 34'(p) * 34'(K16);
      term = 34'(q) * 34'(K16);
      acc  = neg ? (acc - term) : (acc + term);
      acc  = acc + 34'sd8192;
      return s16_t'(acc[29:14]);
   endfunction
endpackage

// File: rtl/spidct_lanes.sv
module spidct_lanes
   import spidct_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [4*W-1:0] x_in,
   output logic [8*W-1:0] y_out
);
   localparam s16_t D4   = 16'(2 * K4);
   localparam s16_t D8   = 16'(2 * K8);
   localparam s16_t D12  = 16'(2 * K12);
   localparam s16_t D16  = 16'(2 * K16);
   localparam s16_t ND20 = 16'(-2 * K20);
   localparam s16_t D24  = 16'(2 * K24);
   localparam s16_t D28  = 16'(2 * K28);

   generate
      if (W != 16) begin : g_bad_width
         $error("spidct_lanes: W must be 16");
      end
   endgenerate

   s16_t x0, x1, x2, x3;
   s16_t s4, s5, s6, s7, e0, e2, e3;
   s16_t t4, t5, t6, t7, a0, a1, a2, a3, r5, r6;
   s16_t y [8];

   assign x0 = s16_t'(x_in[0*W +: W]);
   assign x1 = s16_t'(x_in[1*W +: W]);
   assign x2 = s16_t'(x_in[2*W +: W]);
   assign x3 = s16_t'(x_in[3*W +: W]);

   always_comb begin
      // pruned odd half (R2)
      s4 = qdmulh(x1, D28);
      s7 = qdmulh(x1, D4);
      s5 = qdmulh(x3, ND20);
      s6 = qdmulh(x3, D12);
      // pruned even half; both even outputs share x0 term
      e0 = qdmulh(x0, D16);
      e2 = qdmulh(x2, D24);
      e3 = qdmulh(x2, D8);
      // 16-bit wrapping butterflies (R10)
      t4 = s4 + s5;
      t5 = s4 - s5;
      t6 = s7 - s6;
      t7 = s7 + s6;
      a0 = e0 + e3;
      a1 = e0 + e2;
      a2 = e0 - e2;
      a3 = e0 - e3;
      // full-precision rotation (R3)
      r5 = rot14(t6, t5, 1'b1);
      r6 = rot14(t6, t5, 1'b0);
      y[0] = a0 + t7;
      y[1] = a1 + r6;
      y[2] = a2 + r5;
      y[3] = a3 + t4;
      y[4] = a3 - t4;
      y[5] = a2 - r5;
      y[6] = a1 - r6;
      y[7] = a0 - t7;
   end

   generate
      for (genvar i = 0; i < 8; i++) begin : g_out
         assign y_out[i*W +: W] = y[i];
      end
   endgenerate

   // R5: a lone DC input spreads evenly over all eight outputs
   always_comb begin
      if (x1 == '0 && x2 == '0 && x3 == '0)
         assert_dc_flat_R5: assert (y[0] == y[7] && y[1] == y[6] && y[2] == y[5]
                                    && y[3] == y[4] && y[0] == y[3]);
   end
endmodule

// File: rtl/spidct_recon.sv
module spidct_recon #(
   parameter int W     = 16,
   parameter int PIX_W = 8,
   parameter int SHIFT = 5
) (
   input  logic [W-1:0]     res_in,
   input  logic [PIX_W-1:0] pred_in,
   output logic [PIX_W-1:0] pix_out
);
   localparam int HALF = 1 << (SHIFT - 1);
   localparam logic signed [W+1:0] MAXP = (W+2)'((1 << PIX_W) - 1);

   generate
      if (SHIFT < 1 || SHIFT >= W) begin : g_bad_shift
         $error("spidct_recon: SHIFT out of range");
      end
      if (PIX_W >= W) begin : g_bad_pix
         $error("spidct_recon: PIX_W must be narrower than W");
      end
   endgenerate

   logic signed [W:0]   biased;
   logic signed [W:0]   scaled;
   logic signed [W+1:0] sum;

   always_comb begin
      biased = $signed({res_in[W-1], res_in}) + $signed((W+1)'(HALF));
      scaled = biased >>> SHIFT;
      sum    = $signed({scaled[W], scaled}) + $signed({{(W+2-PIX_W){1'b0}}, pred_in});
      if (sum < 0)         pix_out = '0;
      else if (sum > MAXP) pix_out = MAXP[PIX_W-1:0];
      else                 pix_out = sum[PIX_W-1:0];
   end

   always_comb begin
      if (res_in == '0)
         assert_zero_res_R8: assert (pix_out == pred_in);
      if (scaled > 0)
         assert_clamp_up_R4: assert (pix_out >= pred_in);
      if (scaled < 0)
         assert_clamp_down_R9: assert (pix_out <= pred_in);
   end
endmodule

// File: rtl/sparse_idct8_recon.sv
module sparse_idct8_recon #(
   parameter int COEF_W    = 16,
   parameter int PIX_W     = 8,
   parameter int REG_MID   = 1,
   parameter int SHIFT_OUT = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [16*COEF_W-1:0]  coef_in,
   input  logic [64*PIX_W-1:0]   pred_in,
   output logic                  out_valid,
   output logic [64*PIX_W-1:0]   pix_out
);
   localparam int N    = 8;
   localparam int H    = N / 2;
   localparam int NPIX = N * N;

   generate
      if (COEF_W != 16) begin : g_bad_coef
         $error("sparse_idct8_recon: COEF_W must be 16");
      end
      if (REG_MID != 0 && REG_MID != 1) begin : g_bad_mid
         $error("sparse_idct8_recon: REG_MID must be 0 or 1");
      end
   endgenerate

   logic [N*COEF_W-1:0]    row_res [H];
   logic [N*COEF_W-1:0]    row_q   [H];
   logic [NPIX*PIX_W-1:0]  pred_q;
   logic                   s2_v;
   logic [H*COEF_W-1:0]    col_in  [N];
   logic [N*COEF_W-1:0]    col_res [N];
   logic [NPIX*PIX_W-1:0]  pix_c;

   // row pass on the four populated rows (R1)
   generate
      for (genvar r = 0; r < H; r++) begin : g_rows
         spidct_lanes #(.W(COEF_W)) u_row (
            .x_in  (coef_in[r*H*COEF_W +: H*COEF_W]),
            .y_out (row_res[r])
         );
      end
   endgenerate

   // optional register between passes
   generate
      if (REG_MID == 1) begin : g_mid_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s2_v   <= 1'b0;
               pred_q <= '0;
               for (int r = 0; r < H; r++) row_q[r] <= '0;
            end else begin
               s2_v <= in_valid;
               if (in_valid) begin
                  pred_q <= pred_in;
                  for (int r = 0; r < H; r++) row_q[r] <= row_res[r];
               end
            end
         end
         assert_mid_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> s2_v);
      end else begin : g_mid_wire
         assign s2_v   = in_valid;
         assign pred_q = pred_in;
         for (genvar r = 0; r < H; r++) begin : g_pass
            assign row_q[r] = row_res[r];
         end
      end
   endgenerate

   // 4x8 turn and column pass, then reconstruction
   generate
      for (genvar k = 0; k < N; k++) begin : g_cols
         for (genvar r = 0; r < H; r++) begin : g_turn
            assign col_in[k][r*COEF_W +: COEF_W] = row_q[r][k*COEF_W +: COEF_W];
         end
         spidct_lanes #(.W(COEF_W)) u_col (
            .x_in  (col_in[k]),
            .y_out (col_res[k])
         );
         for (genvar m = 0; m < N; m++) begin : g_pix
            spidct_recon #(.W(COEF_W), .PIX_W(PIX_W), .SHIFT(SHIFT_OUT)) u_rec (
               .res_in  (col_res[k][m*COEF_W +: COEF_W]),
               .pred_in (pred_q[(m*N+k)*PIX_W +: PIX_W]),
               .pix_out (pix_c[(m*N+k)*PIX_W +: PIX_W])
            );
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pix_out   <= '0;
      end else begin
         out_valid <= s2_v;
         if (s2_v) pix_out <= pix_c;
      end
   end

   assert_out_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      s2_v |=> out_valid);
   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !s2_v |=> (!out_valid && $stable(pix_out)));
endmodule

// File: tb/sparse_idct8_recon_test.sv
module sparse_idct8_recon_test;
   localparam int PERIOD = 10;
   localparam int CW = 16;
   localparam int PW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [16*CW-1:0] coef = '0;
   logic [64*PW-1:0] pred = '0;
   logic ov_a, ov_b;
   logic [64*PW-1:0] pix_a, pix_b, hold_a, hold_b;

   int n_chk = 0;
   int n_bad = 0;
   int cf [8][8];
   int pd [8][8];
   int ex [8][8];
   logic [64*PW-1:0] exp_vec;

   always #(PERIOD/2) clk = ~clk;

   sparse_idct8_recon #(.REG_MID(1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coef_in(coef),
      .pred_in(pred), .out_valid(ov_a), .pix_out(pix_a));

   sparse_idct8_recon #(.REG_MID(0)) uut_flat (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coef_in(coef),
      .pred_in(pred), .out_valid(ov_b), .pix_out(pix_b));

   function automatic int w16(longint v);
      return int'(shortint'(v));
   endfunction

   function automatic int r14(longint p);
      return w16((p + 64'sd8192) >>> 14);
   endfunction

   // full eight-input inverse DCT, 16-bit wrap as the reference
   function automatic void idct8_full(input int x[8], output int y[8]);
      int s4, s5, s6, s7, e0, e1, e2, e3, t4, t5, t6, t7, a0, a1, a2, a3, r5, r6;
      s4 = r14(longint'(x[1])*3196  - longint'(x[7])*16069);
      s7 = r14(longint'(x[1])*16069 + longint'(x[7])*3196);
      s5 = r14(longint'(x[5])*13623 - longint'(x[3])*9102);
      s6 = r14(longint'(x[5])*9102  + longint'(x[3])*13623);
      e0 = r14(longint'(x[0])*11585 + longint'(x[4])*11585);
      e1 = r14(longint'(x[0])*11585 - longint'(x[4])*11585);
      e2 = r14(longint'(x[2])*6270  - longint'(x[6])*15137);
      e3 = r14(longint'(x[2])*15137 + longint'(x[6])*6270);
      t4 = w16(s4 + s5); t5 = w16(s4 - s5);
      t6 = w16(s7 - s6); t7 = w16(s7 + s6);
      a0 = w16(e0 + e3); a1 = w16(e1 + e2);
      a2 = w16(e1 - e2); a3 = w16(e0 - e3);
      r5 = r14(longint'(t6)*11585 - longint'(t5)*11585);
      r6 = r14(longint'(t6)*11585 + longint'(t5)*11585);
      y[0] = w16(a0 + t7); y[1] = w16(a1 + r6);
      y[2] = w16(a2 + r5); y[3] = w16(a3 + t4);
      y[4] = w16(a3 - t4); y[5] = w16(a2 - r5);
      y[6] = w16(a1 - r6); y[7] = w16(a0 - t7);
   endfunction

   task automatic build_expect();
      int mid [8][8];
      int xv [8];
      int yv [8];
      for (int r = 0; r < 8; r++) begin
         for (int c = 0; c < 8; c++) xv[c] = cf[r][c];
         idct8_full(xv, yv);
         for (int c = 0; c < 8; c++) mid[r][c] = yv[c];
      end
      for (int k = 0; k < 8; k++) begin
         for (int r = 0; r < 8; r++) xv[r] = mid[r][k];
         idct8_full(xv, yv);
         for (int m = 0; m < 8; m++) begin
            int v;
            v = ((yv[m] + 16) >>> 5) + pd[m][k];
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            ex[m][k] = v;
            exp_vec[(m*8+k)*8 +: 8] = 8'(v);
         end
      end
   endtask

   task automatic check_bit(input string tag, input logic got, input logic want);
      n_chk++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, got, want);
      end
   endtask

   task automatic check_tile(input string tag, input logic [64*PW-1:0] got);
      n_chk++;
      if (got !== exp_vec) begin
         n_bad++;
         for (int i = 0; i < 64; i++) begin
            if (got[i*8 +: 8] !== exp_vec[i*8 +: 8]) begin
               $display("FAIL %s: pixel(%0d,%0d) got %0d expected %0d",
                        tag, i/8, i%8, got[i*8 +: 8], exp_vec[i*8 +: 8]);
               break;
            end
         end
      end
   endtask

   task automatic clear_block();
      for (int r = 0; r < 8; r++)
         for (int c = 0; c < 8; c++) cf[r][c] = 0;
   endtask

   task automatic run_block(input string tag);
      build_expect();
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++) coef[(r*4+c)*16 +: 16] = 16'(cf[r][c]);
      for (int i = 0; i < 64; i++) pred[i*8 +: 8] = 8'(pd[i/8][i%8]);
      in_valid = 1'b1;
      @(negedge clk);
      // single-cycle variant is ready now
      check_bit({tag, " R6 flat valid"}, ov_b, 1'b1);
      check_tile({tag, " flat"}, pix_b);
      in_valid = 1'b0;
      coef = {8{$urandom()}};
      pred = {16{$urandom()}};
      @(negedge clk);
      check_bit({tag, " R6 reg valid"}, ov_a, 1'b1);
      check_tile({tag, " reg"}, pix_a);
      hold_a = pix_a;
      hold_b = pix_b;
      coef = {8{$urandom()}};
      @(negedge clk);
      check_bit({tag, " R6 valid drop"}, ov_a | ov_b, 1'b0);
      n_chk++;
      if (pix_a !== hold_a || pix_b !== hold_b) begin
         n_bad++;
         $display("FAIL %s R6 hold: got %0h expected %0h", tag, pix_a, hold_a);
      end
   endtask

   task automatic fill_pred(input int base, input int span);
      for (int m = 0; m < 8; m++)
         for (int k = 0; k < 8; k++)
            pd[m][k] = (span == 0) ? base : base + int'($urandom_range(span));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250611));
      clear_block();
      fill_pred(0, 0);
      repeat (3) @(negedge clk);
      // R7: cleared under reset
      check_bit("R7 reset valid", ov_a | ov_b, 1'b0);
      n_chk++;
      if (pix_a !== '0 || pix_b !== '0) begin
         n_bad++;
         $display("FAIL R7 reset pixels: got %0h expected 0", pix_a);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R8: zero coefficients return the prediction
      clear_block(); fill_pred(0, 255);
      run_block("R8 zero coefs");

      // R5: DC only gives a flat offset
      clear_block(); cf[0][0] = 640; fill_pred(90, 0);
      run_block("R5 dc flat");
      n_chk++;
      for (int i = 1; i < 64; i++)
         if (ex[i/8][i%8] != ex[0][0]) begin
            n_bad++;
            $display("FAIL R5 flat model: got %0d expected %0d", ex[i/8][i%8], ex[0][0]);
            break;
         end

      // R9: clamp high and low
      clear_block(); cf[0][0] = 20000; fill_pred(200, 55);
      run_block("R9 clamp high");
      clear_block(); cf[0][0] = -20000; fill_pred(0, 60);
      run_block("R9 clamp low");

      // R2: single odd and even terms
      clear_block(); cf[0][1] = 1234; cf[2][0] = -777; fill_pred(128, 0);
      run_block("R2 single terms");

      // R3: rotation exercised by both odd inputs
      clear_block(); cf[1][1] = 3000; cf[1][3] = -2500; cf[3][1] = 1800; cf[3][3] = 2100;
      fill_pred(100, 50);
      run_block("R3 rotation");

      // R10: full-range values drive 16-bit wrap
      clear_block();
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++) cf[r][c] = ((r + c) % 2 == 0) ? 32767 : -32768;
      fill_pred(0, 255);
      run_block("R10 extreme");

      // R1: random sparse blocks against the full transform
      for (int n = 0; n < 300; n++) begin
         int lim;
         clear_block();
         lim = (n % 5 == 0) ? 32767 : ((n % 2 == 0) ? 2047 : 255);
         for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
               if ($urandom_range(3) != 0)
                  cf[r][c] = int'($urandom_range(2*lim + 1)) - lim - 1;
         fill_pred(0, 255);
         run_block((n % 5 == 0) ? "R1 random R10 wide" : "R1 random");
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule